// File: doc/BRIEF.md
# Four-Channel Hit Load and Merge Sequencer

This block is the shared readout stage behind four time-to-digital sampling channels. Each channel keeps a sampling register that takes a new delay-line pattern on every fast clock edge. When the sampled pattern is non-zero, the channel treats it as a hit and freezes, so the captured pattern stays stable. The rest of the stage runs at one quarter of the fast rate. It is built here as a slow-cycle enable in the same clock domain, active on every fourth fast edge.

Every fourth slow cycle, four transfer registers all load in parallel, one per channel. Each loaded word carries a valid bit, a 2-bit channel tag and the pattern. Loading releases the freeze of every channel, so each hit enters the transfer path once and only once. In the three slow cycles between loads, the registers shift one place per slow cycle toward the head. The one encoder therefore sees the four channels in turn. The encoder turns the head pattern into a fine-time code, which is the count of set bits. A buffer then keeps only the words marked valid and presents them on a valid/ready output. It raises a stall flag while it is full.

A non-zero pattern that reaches a channel while it is frozen is lost. Each fast cycle that this happens adds one to that channel's saturating overflow counter.

Top module: `hit_merge_seq`

## Requirements
- R1: After synchronous reset, out_valid and stall_o are low and every overflow counter is zero.
- R2: Each captured pattern produces one output word. Its out_tag is the channel index in binary (0 to 3), and its out_fine is the number of set bits in the captured pattern.
- R3: A channel captures on any fast edge where it is not frozen and its input is non-zero. It then holds that pattern frozen until the next load edge, and the pattern is delivered exactly once.
- R4: Fast edges are counted from the first rising edge with reset low, which is edge 1. The slow enable is active on edges 4n, and load edges are edges 16m+4. All four transfer registers load together. Words from one load round leave in tag order 0, 1, 2, 3.
- R5: On each fast edge where a frozen channel sees a non-zero input, that input is lost and the channel's overflow counter rises by one. The counter saturates at all ones.
- R6: A load edge releases the freeze. A pattern presented on the load edge itself is lost and counted. A pattern presented on the next fast edge is captured.
- R7: At a load, a channel that is not frozen yields an empty word. Empty words are never written to the output buffer, so idle inputs produce no output.
- R8: The output buffer holds DEPTH words. While it is full, stall_o is high and newly arriving valid words are dropped. The stored words are later delivered in arrival order.
- R9: Suppose a channel is frozen at load edge L and its tag is k. Its word is written at edge L+4(k+1), and out_valid is high right after that edge.
- R10: The output hands over one word on each fast edge where out_valid and out_ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; the slow stages use an enable on every fourth edge |
| rst | input | 1 | Synchronous reset, active high |
| pat_i | input | NCH*PAT_W | Sampled delay-line patterns; channel k uses bits [k*PAT_W +: PAT_W] |
| ovf_o | output | NCH*OVF_W | Per-channel lost-hit counters; channel k uses bits [k*OVF_W +: OVF_W] |
| out_valid | output | 1 | Buffer holds at least one word |
| out_ready | input | 1 | Consumer accepts the presented word |
| out_tag | output | 2 | Source channel of the presented word |
| out_fine | output | FINE_W | Fine-time code (set-bit count) of the presented word |
| stall_o | output | 1 | Buffer is full; new words are dropped |

## Verification
Two events can land on the same fast edge. One is the load that releases a channel. The other is a new non-zero pattern at that channel's input. The bench aligns itself to the known load-edge numbering and freezes channel 0 with an early pulse. It then presents one pattern exactly on the load edge and a second on the following edge. The expected result is two delivered words, holding the first and third patterns, and an overflow count that rose by exactly one. A second collision is a buffer write arriving while the buffer is full. The bench provokes it by sending three rounds of four hits with the consumer held off. It then drains the buffer and checks that only the first eight fine codes come out, in order.

// File: rtl/hms_pkg.sv
package hms_pkg;

    localparam int NCH    = 4;
    localparam int TAG_W  = $clog2(NCH);
    localparam int PAT_W  = 16;
    localparam int FINE_W = $clog2(PAT_W + 1);
    localparam int RATIO  = 4;

    // word travelling through the transfer chain
    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [PAT_W-1:0] pat;
    } xfer_t;

    // encoded record kept in the output buffer
    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [FINE_W-1:0] fine;
    } rec_t;

    function automatic logic [FINE_W-1:0] fine_code(input logic [PAT_W-1:0] p);
        logic [FINE_W-1:0] n;
        n = '0;
        for (int i = 0; i < PAT_W; i++) n = n + FINE_W'(p[i]);
        return n;
    endfunction

endpackage

// File: rtl/hms_sampler.sv
module hms_sampler
    import hms_pkg::*;
#(
    parameter int OVF_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PAT_W-1:0] pat_i,
    output logic [PAT_W-1:0] hold_o,
    output logic             frozen_o,
    output logic [OVF_W-1:0] ovf_o
);

    localparam logic [OVF_W-1:0] OVF_MAX = '1;

    logic hit;
    assign hit = |pat_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_o   <= '0;
            frozen_o <= 1'b0;
            ovf_o    <= '0;
        end else if (frozen_o) begin
            // held pattern is stable; the load edge releases it
            if (load) frozen_o <= 1'b0;
            if (hit && ovf_o != OVF_MAX) ovf_o <= ovf_o + 1'b1;
        end else begin
            hold_o   <= pat_i;
            frozen_o <= hit;
        end
    end

endmodule

// File: rtl/hms_chain.sv
module hms_chain
    import hms_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       slow_en,
    input  logic                       load,
    input  logic [NCH-1:0]             frz,
    input  logic [NCH-1:0][PAT_W-1:0]  hold,
    output xfer_t                      head_o
);

    xfer_t stage [NCH];

    for (genvar k = 0; k < NCH; k++) begin : g_stage
        xfer_t fresh;
        assign fresh = '{vld: frz[k], tag: TAG_W'(k), pat: (frz[k] ? hold[k] : '0)};

        if (k < NCH - 1) begin : g_mid
            always_ff @(posedge clk) begin
                if (rst)          stage[k] <= '0;
                else if (slow_en) stage[k] <= load ? fresh : stage[k+1];
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst)          stage[k] <= '0;
                else if (slow_en) stage[k] <= load ? fresh : '0;
            end
        end
    end

    assign head_o = stage[0];

endmodule

// File: rtl/hms_zsbuf.sv
module hms_zsbuf
    import hms_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_vld,
    input  rec_t wr_data,
    output logic full_o,
    output logic rd_vld,
    input  logic rd_rdy,
    output rec_t rd_data
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    rec_t          mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          push, pop;

    assign full_o  = (cnt == CW'(DEPTH));
    assign rd_vld  = (cnt != '0);
    assign push    = wr_en && wr_vld && !full_o;
    assign pop     = rd_vld && rd_rdy;
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/hit_merge_seq.sv
module hit_merge_seq
    import hms_pkg::*;
#(
    parameter int OVF_W = 8,
    parameter int DEPTH = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NCH*PAT_W-1:0]   pat_i,
    output logic [NCH*OVF_W-1:0]   ovf_o,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [TAG_W-1:0]       out_tag,
    output logic [FINE_W-1:0]      out_fine,
    output logic                   stall_o
);

    localparam int PH_W = (RATIO > 1) ? $clog2(RATIO) : 1;

    logic [PH_W-1:0]             phase;
    logic [TAG_W-1:0]            slot;
    logic                        slow_en;
    logic                        load;
    logic [NCH-1:0]              frz;
    logic [NCH-1:0][PAT_W-1:0]   hold;
    xfer_t                       head;
    rec_t                        enc;
    rec_t                        rd_rec;

    assign slow_en = (phase == PH_W'(RATIO - 1));
    assign load    = slow_en && (slot == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            slot  <= '0;
        end else begin
            phase <= slow_en ? '0 : phase + 1'b1;
            if (slow_en) slot <= (slot == TAG_W'(NCH - 1)) ? '0 : slot + 1'b1;
        end
    end

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        hms_sampler #(.OVF_W(OVF_W)) u_smp (
            .clk      (clk),
            .rst      (rst),
            .load     (load),
            .pat_i    (pat_i[k*PAT_W +: PAT_W]),
            .hold_o   (hold[k]),
            .frozen_o (frz[k]),
            .ovf_o    (ovf_o[k*OVF_W +: OVF_W])
        );
    end

    hms_chain u_chain (
        .clk     (clk),
        .rst     (rst),
        .slow_en (slow_en),
        .load    (load),
        .frz     (frz),
        .hold    (hold),
        .head_o  (head)
    );

    // shared encoder: thermometer pattern to set-bit count
    always_comb begin
        enc.tag  = head.tag;
        enc.fine = fine_code(head.pat);
    end

    hms_zsbuf #(.DEPTH(DEPTH)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (slow_en),
        .wr_vld  (head.vld),
        .wr_data (enc),
        .full_o  (stall_o),
        .rd_vld  (out_valid),
        .rd_rdy  (out_ready),
        .rd_data (rd_rec)
    );

    assign out_tag  = rd_rec.tag;
    assign out_fine = rd_rec.fine;

endmodule

// File: rtl/hms_chk.sv
module hms_chk
    import hms_pkg::*;
#(
    parameter int OVF_W = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 slow_en,
    input logic                 load,
    input logic                 stall_o,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [NCH-1:0]       frz,
    input logic [NCH*PAT_W-1:0] pat_i,
    input logic [NCH*OVF_W-1:0] ovf_o
);

    localparam logic [OVF_W-1:0] OVF_MAX = '1;

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (stall_o && !out_ready) |=> stall_o);

    p_stall_valid_r8: assert property (@(posedge clk) disable iff (rst)
        stall_o |-> out_valid);

    p_slow_gap_r4: assert property (@(posedge clk) disable iff (rst)
        slow_en |=> !slow_en);

    p_load_slow_r4: assert property (@(posedge clk) disable iff (rst)
        load |-> slow_en);

    for (genvar k = 0; k < NCH; k++) begin : g_chk
        p_hold_frozen_r3: assert property (@(posedge clk) disable iff (rst)
            (frz[k] && !load) |=> frz[k]);

        p_release_r6: assert property (@(posedge clk) disable iff (rst)
            (frz[k] && load) |=> !frz[k]);

        p_ovf_step_r5: assert property (@(posedge clk) disable iff (rst)
            (frz[k] && (|pat_i[k*PAT_W +: PAT_W]) && ovf_o[k*OVF_W +: OVF_W] != OVF_MAX)
            |=> ovf_o[k*OVF_W +: OVF_W] == OVF_W'($past(ovf_o[k*OVF_W +: OVF_W]) + 1'b1));

        p_ovf_still_r5: assert property (@(posedge clk) disable iff (rst)
            (!frz[k] || !(|pat_i[k*PAT_W +: PAT_W])) |=> $stable(ovf_o[k*OVF_W +: OVF_W]));
    end

endmodule

bind hit_merge_seq hms_chk #(.OVF_W(OVF_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .slow_en   (slow_en),
    .load      (load),
    .stall_o   (stall_o),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .frz       (frz),
    .pat_i     (pat_i),
    .ovf_o     (ovf_o)
);

// File: tb/test_hit_merge_seq.sv
module test_hit_merge_seq;
    import hms_pkg::*;

    localparam int OVF_W = 8;
    localparam int DEPTH = 8;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [NCH*PAT_W-1:0]  pat = '0;
    logic [NCH*OVF_W-1:0]  ovf;
    logic                  out_valid;
    logic                  out_ready = 1'b0;
    logic [TAG_W-1:0]      out_tag;
    logic [FINE_W-1:0]     out_fine;
    logic                  stall_o;

    hit_merge_seq #(.OVF_W(OVF_W), .DEPTH(DEPTH)) i_hit_merge_seq (
        .clk       (clk),
        .rst       (rst),
        .pat_i     (pat),
        .ovf_o     (ovf),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_tag   (out_tag),
        .out_fine  (out_fine),
        .stall_o   (stall_o)
    );

    always #5 clk = ~clk;

    int edge_n = 0;
    always @(posedge clk) begin
        if (rst) edge_n <= 0;
        else     edge_n <= edge_n + 1;
    end

    int n_chk = 0;
    int n_bad = 0;
    int n_got = 0;
    int got_tag  [256];
    int got_fine [256];

    always @(negedge clk) begin
        if (!rst && out_valid && out_ready && n_got < 256) begin
            got_tag[n_got]  = int'(out_tag);
            got_fine[n_got] = int'(out_fine);
            n_got = n_got + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic go(input int k);
        while (edge_n < k) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    function automatic int next_load();
        int l;
        l = edge_n + 2;
        while (l % 16 != 4) l++;
        return l;
    endfunction

    function automatic logic [PAT_W-1:0] ones(input int n);
        return (PAT_W'(1) << n) - PAT_W'(1);
    endfunction

    function automatic int ovf_of(input int ch);
        return int'(ovf[ch*OVF_W +: OVF_W]);
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 stall_o", int'(stall_o), 0);
        for (int c = 0; c < NCH; c++) chk("R1 ovf", ovf_of(c), 0);
    endtask

    task automatic t_single();
        logic [PAT_W-1:0] pv [NCH];
        int               pc [NCH];
        int               base, l;
        pv[0] = 16'h0001; pc[0] = 1;
        pv[1] = 16'h00FF; pc[1] = 8;
        pv[2] = 16'hFFFF; pc[2] = 16;
        pv[3] = 16'h0007; pc[3] = 3;
        out_ready = 1'b1;
        for (int c = 0; c < NCH; c++) begin
            base = n_got;
            l = next_load();
            go(l);
            pat[c*PAT_W +: PAT_W] = pv[c];
            step(1);
            pat = '0;
            step(48);
            chk("R3 words per hit", n_got - base, 1);
            chk("R2 tag", got_tag[base], c);
            chk("R2 fine", got_fine[base], pc[c]);
        end
    endtask

    task automatic t_latency();
        int l, base;
        out_ready = 1'b0;
        l = next_load() + 16;
        go(l - 2);
        pat[2*PAT_W +: PAT_W] = 16'h001F;
        step(1);
        pat = '0;
        go(l + 11);
        @(negedge clk);
        chk("R9 not yet valid", int'(out_valid), 0);
        go(l + 12);
        @(negedge clk);
        chk("R9 valid at L+12", int'(out_valid), 1);
        chk("R9 tag", int'(out_tag), 2);
        base = n_got;
        out_ready = 1'b1;
        step(3);
        chk("R10 one word popped", n_got - base, 1);
        chk("R10 fine", got_fine[base], 5);
    endtask

    task automatic t_merge();
        int l, base;
        out_ready = 1'b1;
        base = n_got;
        l = next_load();
        go(l);
        for (int c = 0; c < NCH; c++) pat[c*PAT_W +: PAT_W] = ones(c + 1);
        step(1);
        pat = '0;
        step(48);
        chk("R4 word count", n_got - base, NCH);
        for (int i = 0; i < NCH; i++) begin
            chk("R4 tag order", got_tag[base + i], i);
            chk("R4 fine", got_fine[base + i], i + 1);
        end
    endtask

    task automatic t_overflow();
        int l, base, o0;
        out_ready = 1'b1;
        base = n_got;
        o0 = ovf_of(1);
        l = next_load();
        go(l);
        pat[1*PAT_W +: PAT_W] = 16'h0003;
        step(1);
        pat[1*PAT_W +: PAT_W] = 16'h00F0;
        step(1);
        pat = '0;
        step(48);
        chk("R5 one word", n_got - base, 1);
        chk("R5 first kept", got_fine[base], 2);
        chk("R5 ovf +1", ovf_of(1), o0 + 1);
    endtask

    task automatic t_loadedge();
        int l, base, o0;
        out_ready = 1'b1;
        base = n_got;
        o0 = ovf_of(0);
        l = next_load() + 16;
        go(l - 3);
        pat[0 +: PAT_W] = 16'h0001;
        step(1);
        pat = '0;
        go(l - 1);
        pat[0 +: PAT_W] = 16'h0003;
        step(1);
        pat[0 +: PAT_W] = 16'h0007;
        step(1);
        pat = '0;
        step(48);
        chk("R6 word count", n_got - base, 2);
        chk("R6 first", got_fine[base], 1);
        chk("R6 after load", got_fine[base + 1], 3);
        chk("R6 ovf +1", ovf_of(0), o0 + 1);
    endtask

    task automatic t_idle();
        int base;
        out_ready = 1'b1;
        base = n_got;
        step(64);
        chk("R7 no words", n_got - base, 0);
        @(negedge clk);
        chk("R7 out_valid", int'(out_valid), 0);
    endtask

    task automatic t_full();
        int l, base;
        out_ready = 1'b0;
        for (int r = 0; r < 3; r++) begin
            l = next_load();
            go(l);
            for (int c = 0; c < NCH; c++) pat[c*PAT_W +: PAT_W] = ones(r*4 + c + 1);
            step(1);
            pat = '0;
        end
        step(48);
        @(negedge clk);
        chk("R8 stall high", int'(stall_o), 1);
        chk("R8 valid", int'(out_valid), 1);
        base = n_got;
        step(1);
        out_ready = 1'b1;
        step(24);
        chk("R8 kept words", n_got - base, DEPTH);
        for (int i = 0; i < DEPTH; i++) chk("R8 order", got_fine[base + i], i + 1);
        @(negedge clk);
        chk("R8 stall low", int'(stall_o), 0);
    endtask

    task automatic t_saturate();
        out_ready = 1'b1;
        step(1);
        pat[3*PAT_W +: PAT_W] = 16'h8000;
        step(400);
        pat = '0;
        step(48);
        chk("R5 saturate", ovf_of(3), (1 << OVF_W) - 1);
    endtask

    initial begin
        #(10 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(4);
        rst = 1'b0;
        t_reset();
        t_single();
        t_latency();
        t_merge();
        t_overflow();
        t_loadedge();
        t_idle();
        t_full();
        t_saturate();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule